// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a small word-addressed register bus. A mode register selects whether the interface is on and acting as master. It also sets the bit order, an internal loopback path, a serial clock prescaler and the character length. Writing the transmit register sends one character of 4 to 32 bits. The character returned by the peripheral is assembled into a receive register.

Two event flags report progress. One shows that the transmit word has been taken into the shifter; the other shows that a received character is ready. Software clears each flag by writing a one to its bit. A mask register selects which flags drive a registered interrupt output. Chip-select generation is left to the surrounding logic.

Register word offsets on `bus_addr`: 0 mode, 1 event, 2 mask, 3 transmit (write), 4 receive (read). Reads are combinational on `bus_addr`. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the mode, event, mask and receive registers read zero, and `sclk`, `mosi` and `irq` are low.
- R2: The mode register keeps loopback at bit 30, MSB-first order at bit 26, master at bit 25, enable at bit 24, length at bits 23:20 and prescale at bits 19:16. Every other bit reads back zero.
- R3: A length field n from 3 to 15 gives n+1 bits per character. Zero gives 32 bits, and 1 or 2 give 4 bits.
- R4: The serial clock period is 4*(prescale+1) system clocks, split evenly between high and low. The clock idles low.
- R5: Transmit data is taken from the low bits of the transmit word. Each bit is presented before the rising edge that samples it and changes only after a falling edge. LSB goes first when bit 26 is clear and MSB first when it is set.
- R6: The received character appears right-justified in the receive register. It keeps that value until the next character completes, and an aborted transfer leaves it unchanged.
- R7: Event bit 8 (transmit not full) sets when the transmit word moves into the shifter. Event bit 9 (receive not empty) sets at the edge where the receive register takes the completed character.
- R8: Writing the event register clears each bit written as one and leaves bits written as zero.
- R9: `irq` is the OR of (events AND mask) at bits 9:8, registered one clock later. With a zero mask `irq` stays low.
- R10: With loopback set, the outgoing data feeds the receiver and `miso` is ignored.
- R11: A transmit write is ignored unless enable and master are both set. No serial clock runs and no event sets.
- R12: Clearing enable or master during a transfer stops it. `sclk` returns low and receive-not-empty never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench targets the length decode at its edges: field 0 (32 bits), field 1 (clamped to 4) and fields 3 and 15. A wrong decode shows up as a wrong rising-edge count and a truncated or widened receive word. Each transfer runs with a different prescale and bit order, and the bench compares the `mosi` stream and the receive word against a slave model. A reversed bit index or a data change on the rising edge would scramble those bits.

Loopback is tested with `miso` held at the inverse level, so an ignored loopback select corrupts the receive word. Further tests cover write-one-to-clear on a single bit, the one-clock `irq` lag after a mask change, and transmit writes with only enable or only master set. Aborting mid-character must freeze the clock and leave the previous receive value and a clear not-empty flag; a design that let the transfer finish would fail both checks.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int CNT_W   = 6;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd4;

  localparam int B_LOOP   = 30;
  localparam int B_MSB    = 26;
  localparam int B_MASTER = 25;
  localparam int B_EN     = 24;
  localparam int B_LEN_LO = 20;
  localparam int B_PRE_LO = 16;
  localparam int B_NE     = 9;
  localparam int B_NF     = 8;

  localparam logic [DATA_W-1:0] MODE_KEEP = 32'h47FF_0000;

  // bits per character from the length field
  function automatic logic [CNT_W-1:0] char_bits(input logic [3:0] f);
    if (f == 4'd0)      return CNT_W'(32);
    else if (f < 4'd3)  return CNT_W'(4);
    else                return CNT_W'(f) + CNT_W'(1);
  endfunction

  // system clocks per serial clock half period
  function automatic logic [CNT_W-1:0] half_cycles(input logic [3:0] p);
    return (CNT_W'(p) + CNT_W'(1)) << 1;
  endfunction

endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == half - CNT_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || at_end) cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              abort,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              msb_first,
  input  logic              loop_en,
  input  logic              miso,
  input  logic              tick,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              char_done,
  output logic [DATA_W-1:0] rx_word
);
  logic              busy_q, sclk_q, msb_q, loop_q;
  logic [DATA_W-1:0] tx_q, rx_acc;
  logic [CNT_W-1:0]  bitcnt, len_q, rev_idx;
  logic [4:0]        idx;
  logic              rx_bit, last_bit;

  assign rev_idx  = len_q - CNT_W'(1) - bitcnt;
  assign idx      = msb_q ? rev_idx[4:0] : bitcnt[4:0];
  assign last_bit = (bitcnt == len_q - CNT_W'(1));
  assign mosi     = busy_q && tx_q[idx];
  assign rx_bit   = loop_q ? mosi : miso;
  assign rx_word  = rx_acc | ({{(DATA_W-1){1'b0}}, rx_bit} << idx);
  assign char_done = busy_q && tick && !sclk_q && last_bit && !abort;
  assign busy     = busy_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; msb_q <= 1'b0; loop_q <= 1'b0;
      tx_q <= '0; rx_acc <= '0; bitcnt <= '0; len_q <= CNT_W'(4);
    end else if (abort) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
    end else if (load) begin
      busy_q <= 1'b1; sclk_q <= 1'b0; bitcnt <= '0;
      tx_q <= tx_word; len_q <= nbits; msb_q <= msb_first; loop_q <= loop_en;
      rx_acc <= '0;
    end else if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_acc <= rx_word;
      end else begin
        sclk_q <= 1'b0;
        if (last_bit) busy_q <= 1'b0;
        else          bitcnt <= bitcnt + CNT_W'(1);
      end
    end
  end

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bitcnt < len_q));
  assert_done_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> sclk_q);

endmodule

// File: rtl/spi_host_events.sv
module spi_host_events
  import spi_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ne_set,
  input  logic       nf_set,
  input  logic [1:0] clr,
  input  logic [1:0] mask,
  output logic [1:0] ev,
  output logic       irq
);
  logic [1:0] ev_q, ev_n;
  logic       irq_q;

  assign ev_n = (ev_q & ~clr) | {ne_set, nf_set};
  assign ev   = ev_q;
  assign irq  = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      ev_q  <= ev_n;
      irq_q <= |(ev_n & mask);
    end
  end

  assert_ne_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ne_set |=> ev_q[1]);
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask) == 2'b00) |-> !irq_q);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  logic [DATA_W-1:0] mode_q, hold_q, rx_q, rx_word;
  logic [1:0]        mask_q, ev, clr;
  logic              hold_full, go, tx_wr, load, abort;
  logic              sh_busy, tick, char_done;
  logic [CNT_W-1:0]  half, nbits;

  assign go    = mode_q[B_EN] && mode_q[B_MASTER];
  assign tx_wr = bus_wr && (bus_addr == A_TX) && go && !hold_full;
  assign load  = hold_full && go && !sh_busy;
  assign abort = sh_busy && !go;
  assign half  = half_cycles(mode_q[B_PRE_LO +: 4]);
  assign nbits = char_bits(mode_q[B_LEN_LO +: 4]);
  assign clr   = (bus_wr && bus_addr == A_EVT) ? bus_wdata[B_NE:B_NF] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; mask_q <= '0; hold_q <= '0; hold_full <= 1'b0; rx_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata & MODE_KEEP;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[B_NE:B_NF];
      if (tx_wr) hold_q <= bus_wdata;
      if (!go)        hold_full <= 1'b0;
      else if (tx_wr) hold_full <= 1'b1;
      else if (load)  hold_full <= 1'b0;
      if (char_done) rx_q <= rx_word;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_EVT:   bus_rdata = {22'b0, ev, 8'b0};
      A_MASK:  bus_rdata = {22'b0, mask_q, 8'b0};
      A_RX:    bus_rdata = rx_q;
      default: bus_rdata = '0;
    endcase
  end

  spi_host_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(sh_busy), .half(half), .tick(tick)
  );

  spi_host_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .abort(abort), .tx_word(hold_q),
    .nbits(nbits), .msb_first(mode_q[B_MSB]), .loop_en(mode_q[B_LOOP]),
    .miso(miso), .tick(tick), .busy(sh_busy), .sclk(sclk), .mosi(mosi),
    .char_done(char_done), .rx_word(rx_word)
  );

  spi_host_events u_ev (
    .clk(clk), .rst_n(rst_n), .ne_set(char_done), .nf_set(load),
    .clr(clr), .mask(mask_q), .ev(ev), .irq(irq)
  );

  assert_stop_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !sh_busy);
  assert_no_load_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !hold_full);

endmodule

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, irq;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  spi_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  int total = 0, bad = 0;
  bit ended = 0;

  logic [31:0] pat;
  logic [63:0] mosi_log;
  int rise_cnt = 0, fall_cnt = 0;
  time t_r0, t_r1, t_f0;

  always @(posedge sclk) begin
    mosi_log[rise_cnt[5:0]] = mosi;
    if (rise_cnt == 0) t_r0 = $time;
    if (rise_cnt == 1) t_r1 = $time;
    rise_cnt = rise_cnt + 1;
    miso = pat[rise_cnt[4:0]];
  end
  always @(negedge sclk) begin
    if (fall_cnt == 0) t_f0 = $time;
    fall_cnt = fall_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic int bits_of(input int f);
    if (f == 0) return 32;
    if (f <= 2) return 4;
    return f + 1;
  endfunction

  logic [31:0] last_rx;

  task automatic xfer(input string req, input int f, input int pre, input bit msb,
                      input bit loop, input logic [31:0] tx, input logic [31:0] p);
    int n; logic [31:0] v, exp_rx, exp_tx, got_tx, mode; int hc; bit seen;
    n = bits_of(f); hc = 2 * (pre + 1);
    mode = (32'(loop) << 30) | (32'(msb) << 26) | (32'h1 << 25) |
           (32'(f) << 20) | (32'(pre) << 16);
    wr(3'd0, mode);
    wr(3'd0, mode | (32'h1 << 24));
    wr(3'd1, 32'hFFFF_FFFF);
    pat = p; rise_cnt = 0; fall_cnt = 0; miso = p[0]; mosi_log = '0;
    exp_rx = '0; exp_tx = '0; got_tx = '0;
    for (int k = 0; k < n; k++) begin
      if (loop) exp_rx[k] = tx[k];
      else if (msb) exp_rx[n-1-k] = p[k];
      else exp_rx[k] = p[k];
      exp_tx[k] = msb ? tx[n-1-k] : tx[k];
      got_tx[k] = mosi_log[k];
    end
    wr(3'd3, tx);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, v);
      if (v[9]) begin seen = 1; break; end
    end
    chk(seen, req, "R7 not-empty set", v, 32'h300);
    chk(v[8] == 1'b1, req, "R7 not-full set", v, 32'h300);
    rd(3'd4, v);
    chk(v == exp_rx, req, "R6 rx word", v, exp_rx);
    last_rx = v;
    repeat (2 * hc + 4) @(negedge clk);
    for (int k = 0; k < n; k++) got_tx[k] = mosi_log[k];
    chk(got_tx == exp_tx, req, "R5 mosi order", got_tx, exp_tx);
    chk(rise_cnt == n, req, "R3 edge count", rise_cnt, n);
    chk(sclk == 1'b0, req, "R4 idle low", {31'b0, sclk}, 0);
    chk((t_r1 - t_r0) == time'(4 * (pre + 1) * 20), req, "R4 period",
        32'(t_r1 - t_r0), 32'(4 * (pre + 1) * 20));
    chk((t_f0 - t_r0) == time'(hc * 20), req, "R4 high time",
        32'(t_f0 - t_r0), 32'(hc * 20));
    repeat (40) @(negedge clk);
    rd(3'd4, v);
    chk(v == exp_rx, req, "R6 rx held", v, exp_rx);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1", "reset reg", v, 0);
    end
    chk({sclk, mosi, irq} == 3'b000, "R1", "reset pins", {29'b0, sclk, mosi, irq}, 0);
  endtask

  task automatic t_mode_rw;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v);
    chk(v == 32'h47FF_0000, "R2", "mode readback", v, 32'h47FF_0000);
    wr(3'd0, 32'h0);
    rd(3'd0, v);
    chk(v == 0, "R2", "mode cleared", v, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(3'd1, 32'h0);
    rd(3'd1, v);
    chk(v == 32'h300, "R8", "zero write keeps", v, 32'h300);
    wr(3'd1, 32'h100);
    rd(3'd1, v);
    chk(v == 32'h200, "R8", "clear bit 8 only", v, 32'h200);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v);
    chk(v == 0, "R8", "clear all", v, 0);
  endtask

  task automatic t_irq;
    // events are both set on entry
    wr(3'd2, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R9", "zero mask", {31'b0, irq}, 0);
    wr(3'd2, 32'h200);
    chk(irq == 1'b0, "R9", "lag one clock", {31'b0, irq}, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R9", "ne unmasked", {31'b0, irq}, 1);
    wr(3'd1, 32'h200);
    @(negedge clk);
    chk(irq == 1'b0, "R9", "ne cleared", {31'b0, irq}, 0);
    wr(3'd2, 32'h100);
    @(negedge clk);
    chk(irq == 1'b1, "R9", "nf unmasked", {31'b0, irq}, 1);
    wr(3'd2, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R9", "remasked", {31'b0, irq}, 0);
  endtask

  task automatic t_ignore(input logic [31:0] mode, input string what);
    logic [31:0] v;
    wr(3'd0, mode);
    wr(3'd1, 32'hFFFF_FFFF);
    rise_cnt = 0;
    wr(3'd3, 32'hFFFF_FFFF);
    repeat (100) @(negedge clk);
    chk(rise_cnt == 0, "R11", what, rise_cnt, 0);
    rd(3'd1, v);
    chk(v == 0, "R11", what, v, 0);
  endtask

  task automatic t_abort;
    logic [31:0] v; int rc;
    wr(3'd0, 32'h0203_0000);
    wr(3'd0, 32'h0303_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    rise_cnt = 0;
    wr(3'd3, 32'hDEAD_BEEF);
    repeat (60) @(negedge clk);
    wr(3'd0, 32'h0203_0000);
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R12", "clock stopped", {31'b0, sclk}, 0);
    rc = rise_cnt;
    repeat (400) @(negedge clk);
    chk(rise_cnt == rc && rc < 32, "R12", "no more edges", rise_cnt, rc);
    rd(3'd1, v);
    chk(v[9] == 1'b0, "R12", "no not-empty", v, 32'h100);
    rd(3'd4, v);
    chk(v == last_rx, "R6", "rx kept after abort", v, last_rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_rw();
    xfer("R5", 7, 0, 0, 0, 32'h0000_00A5, 32'h0000_003C);
    xfer("R3", 0, 1, 1, 0, 32'h1234_5678, 32'hC0DE_F00D);
    xfer("R3", 3, 2, 1, 0, 32'hFFFF_FFF9, 32'h0000_0006);
    xfer("R3", 1, 0, 0, 0, 32'h0000_0003, 32'h0000_000A);
    xfer("R5", 15, 3, 0, 0, 32'h0000_9C31, 32'h0000_6E4B);
    t_w1c();
    xfer("R10", 11, 0, 0, 1, 32'h0000_05A3, 32'hFFFF_FFFF);
    t_irq();
    t_ignore(32'h0200_0000, "master only");
    t_ignore(32'h0100_0000, "enable only");
    t_abort();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule